// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single input line. A baud tick input arriving at sixteen times the bit rate drives the sampling. The receiver finds a start bit on a falling edge of the line and confirms it at the middle of the bit. It then samples each data bit, the optional parity bit and the stop bit at the centre of the bit. A completed frame goes into a data register. A data-full flag rises, and a single-cycle receive interrupt pulse marks that rise.

Overrun, parity error and framing error are kept in separate sticky flags. While any of them is set, the receiver starts no new frame. Software reads the data and status words over a small register bus. It clears a flag by writing 0 to its bit. A DMA acknowledge clears the data-full flag with no bus write. The status word also shows the synchronised level of the serial line, so that a line held low after a framing error can be seen as a break.

Top module: `uart_rx_latched`

## Requirements
- R1: With 16 ticks per bit, a low level is taken as a start bit only after the line was high on the previous tick. It must still be low 8 ticks later, or the receiver returns to idle with no frame. Data bits are sampled 16 ticks apart, least significant bit first.
- R2: `cfg_seven`=1 selects 7 data bits and bit 7 of the data word reads 0. `cfg_par_en`=1 adds a parity bit, which is even when `cfg_par_odd`=0 and odd when it is 1. `cfg_two_stop`=1 expects two stop bits, and only the first of them is checked.
- R3: A frame that completes while the data-full flag is 0 loads the data word (`bus_addr`=0) and sets the full flag (status bit 0). `rx_irq` is high for exactly the one cycle in which the full flag goes from 0 to 1.
- R4: A bus write to the status word (`bus_addr`=1) with bit 0 at 0 clears the full flag. Writing 1 to any status bit leaves that bit unchanged.
- R5: A one-cycle pulse on `dma_ack` clears the full flag and changes no other flag.
- R6: A frame that completes while the full flag is set sets the overrun flag (status bit 1). The data word, the full flag and `rx_irq` do not change.
- R7: A parity bit that does not match the configured sense sets the parity-error flag (status bit 2), and the data is still loaded.
- R8: A first stop bit sampled as 0 sets the framing-error flag (status bit 3), and the data is still loaded. Status bit 4 always shows the synchronised line level, so a held-low line reads 0 there.
- R9: Each error flag stays set until a status write puts 0 in its own bit.
- R10: While any error flag is set, no new frame is received. Reception resumes once all three are clear.
- R11: While `rx_en` is 0, the receiver stays idle and accepts no frame.
- R12: After reset the data word is 0, the status word is 0x10 with the line idle high, and `rx_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial data line, idle high |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rx_en | input | 1 | Receive enable |
| cfg_seven | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| dma_ack | input | 1 | DMA read of the data word; clears the full flag |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 1 | 0 = data word, 1 = status word |
| bus_wdata | input | DATA_W | Write data; status bits 0..3 clear on 0 |
| bus_rdata | output | DATA_W | Read data of the addressed word |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
A frame is loaded at the centre of its first stop bit. That is the synchroniser depth plus one tick plus one register after the stop-bit centre reaches the pin. The full flag, the error flags and `rx_irq` all change on that same clock edge. The bench therefore reads results only after the complete stop period and one further idle bit time, by which point every result is settled. Interrupt pulses are counted at falling edges. Bus reads are combinational and are sampled one time unit after a falling edge. The line level in status bit 4 is read ten cycles after the line moves, which covers the synchroniser delay.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_GAP
   } rx_state_e;

   typedef struct packed {
      logic seven;
      logic par_en;
      logic par_odd;
      logic two_stop;
   } rx_cfg_t;

   localparam int STAT_FULL = 0;
   localparam int STAT_OVR  = 1;
   localparam int STAT_PAR  = 2;
   localparam int STAT_FRM  = 3;
   localparam int STAT_PIN  = 4;
   localparam int STAT_BITS = 5;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RESET_VAL;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {STAGES{RESET_VAL}};
            else        q <= {q[STAGES-2:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              run,
   input  logic              hold,
   input  rx_cfg_t           cfg,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              par_bad,
   output logic              stop_bad,
   output logic              busy
);

   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] IDX_FULL  = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              armed;
   logic [IDX_W-1:0]  last_idx;
   logic              want_par;
   logic              at_last;

   assign last_idx = cfg.seven ? IDX_SHORT : IDX_FULL;
   assign want_par = HAS_PARITY && cfg.par_en;
   assign at_last  = (cnt == LAST_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         idx      <= '0;
         shreg    <= '0;
         par_bit  <= 1'b0;
         armed    <= 1'b0;
         done     <= 1'b0;
         stop_bad <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            state <= ST_IDLE;
            cnt   <= '0;
            if (tick) armed <= rx;
         end else if (tick) begin
            case (state)
               ST_IDLE: begin
                  armed <= rx;
                  if (!hold && armed && !rx) begin
                     state <= ST_START;
                     cnt   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == HALF_C) begin
                     cnt <= '0;
                     if (!rx) begin
                        state <= ST_DATA;
                        idx   <= '0;
                        shreg <= '0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (at_last) begin
                     cnt        <= '0;
                     shreg[idx] <= rx;
                     if (idx == last_idx) state <= want_par ? ST_PAR : ST_STOP;
                     else                 idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (at_last) begin
                     cnt     <= '0;
                     par_bit <= rx;
                     state   <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (at_last) begin
                     cnt      <= '0;
                     done     <= 1'b1;
                     stop_bad <= !rx;
                     armed    <= rx;
                     state    <= cfg.two_stop ? ST_GAP : ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_GAP: begin
                  if (at_last) begin
                     cnt   <= '0;
                     state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   generate
      if (HAS_PARITY) begin : g_parity
         assign par_bad = cfg.par_en & ((^shreg) ^ par_bit ^ cfg.par_odd);
      end else begin : g_no_parity
         logic unused_par;
         assign unused_par = par_bit ^ cfg.par_odd;
         assign par_bad    = 1'b0;
      end
   endgenerate

   assign data = shreg;
   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              par_bad,
   input  logic              stop_bad,
   input  logic              pin,
   input  logic              dma_ack,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] data_q,
   output logic              full,
   output logic              ovr,
   output logic              perr,
   output logic              ferr,
   output logic              irq
);

   logic wr_stat;
   logic accept;
   logic ovr_hit;
   logic [DATA_W-1:0] stat_word;
   logic unused_wdata;

   assign wr_stat      = bus_sel & bus_wr & bus_addr;
   assign accept       = done & ~full;
   assign ovr_hit      = done & full;
   assign unused_wdata = ^bus_wdata[DATA_W-1:STAT_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full   <= 1'b0;
         ovr    <= 1'b0;
         perr   <= 1'b0;
         ferr   <= 1'b0;
         irq    <= 1'b0;
         data_q <= '0;
      end else begin
         irq <= accept;
         if (accept) data_q <= frame_data;

         if (accept)                                      full <= 1'b1;
         else if (dma_ack || (wr_stat && !bus_wdata[STAT_FULL])) full <= 1'b0;

         if (ovr_hit)                                  ovr <= 1'b1;
         else if (wr_stat && !bus_wdata[STAT_OVR])     ovr <= 1'b0;

         if (accept && par_bad)                        perr <= 1'b1;
         else if (wr_stat && !bus_wdata[STAT_PAR])     perr <= 1'b0;

         if (accept && stop_bad)                       ferr <= 1'b1;
         else if (wr_stat && !bus_wdata[STAT_FRM])     ferr <= 1'b0;
      end
   end

   always_comb begin
      stat_word            = '0;
      stat_word[STAT_FULL] = full;
      stat_word[STAT_OVR]  = ovr;
      stat_word[STAT_PAR]  = perr;
      stat_word[STAT_FRM]  = ferr;
      stat_word[STAT_PIN]  = pin;
   end

   assign bus_rdata = bus_addr ? stat_word : data_q;

endmodule

// File: rtl/uart_rx_latched.sv
module uart_rx_latched
   import uart_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_PARITY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in,
   input  logic              os_tick,
   input  logic              rx_en,
   input  logic              cfg_seven,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              dma_ack,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rx_irq
);

   if (DATA_W < STAT_BITS) begin : g_bad_width
      $error("DATA_W must hold the status word");
   end
   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be even and at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   rx_cfg_t           cfg;
   logic              rx_sync;
   logic              rx_done;
   logic              rx_busy;
   logic [DATA_W-1:0] frame_data;
   logic              par_bad;
   logic              stop_bad;
   logic [DATA_W-1:0] data_q;
   logic              stat_full;
   logic              stat_ovr;
   logic              stat_par;
   logic              stat_frm;
   logic              err_any;

   assign cfg     = '{seven: cfg_seven, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, two_stop: cfg_two_stop};
   assign err_any = stat_ovr | stat_par | stat_frm;

   uart_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_in),
      .dout (rx_sync)
   );

   uart_rx_frame #(
      .DATA_W    (DATA_W),
      .OVERSAMPLE(OVERSAMPLE),
      .HAS_PARITY(HAS_PARITY)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (os_tick),
      .rx      (rx_sync),
      .run     (rx_en),
      .hold    (err_any),
      .cfg     (cfg),
      .done    (rx_done),
      .data    (frame_data),
      .par_bad (par_bad),
      .stop_bad(stop_bad),
      .busy    (rx_busy)
   );

   uart_rx_status #(.DATA_W(DATA_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (rx_done),
      .frame_data(frame_data),
      .par_bad   (par_bad),
      .stop_bad  (stop_bad),
      .pin       (rx_sync),
      .dma_ack   (dma_ack),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .data_q    (data_q),
      .full      (stat_full),
      .ovr       (stat_ovr),
      .perr      (stat_par),
      .ferr      (stat_frm),
      .irq       (rx_irq)
   );

endmodule

// File: rtl/uart_rx_latched_chk.sv
module uart_rx_latched_chk
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              dma_ack,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic              bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              rx_irq,
   input logic              rx_done,
   input logic              rx_busy,
   input logic [DATA_W-1:0] data_q,
   input logic              stat_full,
   input logic              stat_ovr,
   input logic              stat_par,
   input logic              stat_frm
);

   logic par_clear;
   assign par_clear = bus_sel && bus_wr && bus_addr && !bus_wdata[STAT_PAR];

   p_irq_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (stat_full && !$past(stat_full)));

   p_load_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !stat_full) |=> stat_full);

   p_dma_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack && stat_full) |=> !stat_full);

   p_overrun_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_ovr) |-> ($stable(data_q) && !rx_irq));

   p_par_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_par && !par_clear) |=> stat_par);

   p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_ovr || stat_par || stat_frm) && !rx_busy) |=> !rx_busy);

   p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_busy);

endmodule

bind uart_rx_latched uart_rx_latched_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_en    (rx_en),
   .dma_ack  (dma_ack),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .rx_irq   (rx_irq),
   .rx_done  (rx_done),
   .rx_busy  (rx_busy),
   .data_q   (data_q),
   .stat_full(stat_full),
   .stat_ovr (stat_ovr),
   .stat_par (stat_par),
   .stat_frm (stat_frm)
);

// File: tb/uart_rx_latched_test.sv
`timescale 1ns/1ps
module uart_rx_latched_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic       os_tick = 1'b0;
   logic       rx_en = 1'b0;
   logic       cfg_seven = 1'b0;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       dma_ack = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       rx_irq;

   int checks = 0;
   int errors = 0;
   int irq_seen = 0;
   int exp_irq = 0;
   int tick_div = 1;
   int tick_cnt = 0;
   bit finished = 1'b0;

   uart_rx_latched uut (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick), .rx_en(rx_en),
      .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_two_stop(cfg_two_stop), .dma_ack(dma_ack), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .rx_irq(rx_irq)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (tick_cnt >= tick_div - 1) tick_cnt = 0;
      else                          tick_cnt = tick_cnt + 1;
      os_tick = (tick_cnt == 0);
      if (rx_irq) irq_seen = irq_seen + 1;
   end

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks = checks + 1;
      if (got !== exp) begin
         errors = errors + 1;
         $display("FAIL %s got %02h exp %02h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic wr_status(input logic [7:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = v;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic hold_bit(input logic v);
      rx_in = v;
      repeat (16 * tick_div) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input bit flip_par, input bit bad_stop);
      int n;
      logic [7:0] m;
      n = cfg_seven ? 7 : 8;
      m = cfg_seven ? 8'h7F : 8'hFF;
      hold_bit(1'b0);
      for (int i = 0; i < n; i++) hold_bit(d[i]);
      if (cfg_par_en) hold_bit((^(d & m)) ^ cfg_par_odd ^ flip_par);
      hold_bit(!bad_stop);
      if (cfg_two_stop) hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic expect_word(input string tag, input logic a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors = errors + 1;
         $display("FAIL watchdog got 0 exp 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R12 reset state
      expect_word("R12 data", 1'b0, 8'h00);
      expect_word("R12 status", 1'b1, 8'h10);
      check("R12 irq", 8'(irq_seen), 8'h00);

      rx_en = 1'b1;
      repeat (40) @(negedge clk);

      // R1/R3/R4 exhaustive 8N1 sweep
      for (int d = 0; d < 256; d++) begin
         send(8'(d), 1'b0, 1'b0);
         exp_irq++;
         expect_word("R1 data", 1'b0, 8'(d));
         expect_word("R3 full", 1'b1, 8'h11);
         check("R3 irq count", 8'(irq_seen), 8'(exp_irq));
         if (d == 3) begin
            wr_status(8'hFF);
            expect_word("R4 write ones", 1'b1, 8'h11);
         end
         wr_status(8'hFE);
         expect_word("R4 clear", 1'b1, 8'h10);
      end

      // R2/R5 format sweep, cleared by DMA acknowledge
      tick_div = 2;
      for (int c = 0; c < 16; c++) begin
         cfg_seven = c[0]; cfg_par_en = c[1]; cfg_par_odd = c[2]; cfg_two_stop = c[3];
         for (int k = 0; k < 5; k++) begin
            logic [7:0] pat;
            pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 :
                  (k == 3) ? 8'h5A : 8'h3C;
            send(pat, 1'b0, 1'b0);
            exp_irq++;
            expect_word("R2 data", 1'b0, cfg_seven ? (pat & 8'h7F) : pat);
            expect_word("R2 status", 1'b1, 8'h11);
            @(negedge clk); dma_ack = 1'b1;
            @(negedge clk); dma_ack = 1'b0;
            expect_word("R5 dma clear", 1'b1, 8'h10);
         end
      end
      check("R2 irq count", 8'(irq_seen), 8'(exp_irq));

      // R1 short start glitch rejected
      tick_div = 1;
      cfg_seven = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
      rx_in = 1'b0; repeat (4) @(negedge clk); rx_in = 1'b1;
      repeat (48) @(negedge clk);
      expect_word("R1 glitch", 1'b1, 8'h10);
      send(8'h96, 1'b0, 1'b0); exp_irq++;
      expect_word("R1 after glitch", 1'b0, 8'h96);
      wr_status(8'hFE);

      // R7 parity error, 8E1
      cfg_par_en = 1'b1;
      send(8'h3C, 1'b1, 1'b0); exp_irq++;
      expect_word("R7 status", 1'b1, 8'h15);
      expect_word("R7 data", 1'b0, 8'h3C);
      // R9 sticky, R10 blocked
      wr_status(8'hFE);
      expect_word("R9 parity sticky", 1'b1, 8'h14);
      send(8'h77, 1'b0, 1'b0);
      expect_word("R10 blocked status", 1'b1, 8'h14);
      expect_word("R10 blocked data", 1'b0, 8'h3C);
      wr_status(8'h00);
      expect_word("R9 cleared", 1'b1, 8'h10);
      send(8'h77, 1'b0, 1'b0); exp_irq++;
      expect_word("R10 resumed", 1'b0, 8'h77);
      wr_status(8'hFE);

      // R8 framing error and break level
      cfg_par_en = 1'b0;
      send(8'h81, 1'b0, 1'b1); exp_irq++;
      expect_word("R8 status", 1'b1, 8'h19);
      expect_word("R8 data", 1'b0, 8'h81);
      rx_in = 1'b0; repeat (10) @(negedge clk);
      expect_word("R8 break level", 1'b1, 8'h09);
      rx_in = 1'b1; repeat (10) @(negedge clk);
      wr_status(8'hF7);
      expect_word("R9 frame flag only", 1'b1, 8'h11);
      wr_status(8'h00);

      // R6 overrun
      send(8'h11, 1'b0, 1'b0); exp_irq++;
      send(8'h22, 1'b0, 1'b0);
      expect_word("R6 status", 1'b1, 8'h13);
      expect_word("R6 data", 1'b0, 8'h11);
      check("R6 irq count", 8'(irq_seen), 8'(exp_irq));
      wr_status(8'h00);

      // R11 disabled
      rx_en = 1'b0;
      send(8'h55, 1'b0, 1'b0);
      expect_word("R11 no frame", 1'b1, 8'h10);
      expect_word("R11 data kept", 1'b0, 8'h11);
      rx_en = 1'b1;
      repeat (20) @(negedge clk);
      send(8'h66, 1'b0, 1'b0); exp_irq++;
      expect_word("R11 re-enabled", 1'b0, 8'h66);
      check("R3 final irq count", 8'(irq_seen), 8'(exp_irq));

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule